// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Lookup

This block is the lookup and fill path of a small data cache. Each line holds a single 32-bit word, and there are 256 sets of four ways. A request carries a byte address and an operation: read, or word write. The address tag is compared against the four stored tags of the selected set in parallel. On a read hit the stored word is returned at once. On a read miss the word is fetched from a memory port and placed in a victim way of the set. That way is an empty one if the set has one, and otherwise the least recently used way.

Writes are write-through with no allocate. Every write goes out on the memory port. A resident copy is updated in place, and a miss leaves the cache contents untouched.

All three data paths are valid/ready channels: the request channel, the response channel and the memory port. The block accepts one request and raises `req_ready` again only after it has delivered that request's response. A payload that is offered with valid high stays stable until ready is seen at a rising edge, and this holds in both directions. The response may be stalled for any number of cycles by holding `rsp_ready` low. The memory request channel may likewise be stalled through `mem_req_ready`. Each memory read is answered by exactly one beat on the memory response channel, which the block takes when it is waiting for that beat.

Top module: `sa4_cache_lookup`

## Requirements
- R1: The address splits into a tag (bits 31:10), a set index (bits 9:2) and a byte offset (bits 1:0). The byte offset has no effect on hit, data or memory address. Equal tags in different sets are independent entries.
- R2: A read whose tag matches a valid way of its set responds with that way's word and `rsp_hit`=1, and issues no memory request.
- R3: A read miss issues one memory read at the word-aligned address (bits 1:0 zero). It responds with the returned word and `rsp_hit`=0, and that word then hits on later reads.
- R4: While a set has an invalid way, a fill goes into an invalid way. Four different tags read into one set all remain resident.
- R5: When all four ways are valid, a fill replaces the way least recently touched by a hit or a fill in that set.
- R6: Every write issues one memory write carrying the word-aligned address and the write data. On a write hit the stored word is replaced and the way becomes most recently used. The write response returns the write data with `rsp_hit` equal to whether the word was resident.
- R7: A write miss changes neither the stored entries nor the replacement order. A later read of that address misses and returns the memory's new value.
- R8: For any set, no more than one way matches a given tag.
- R9: Only one request is in flight at a time. `req_ready` drops after an accepted request. `rsp_valid` with its payload, and `mem_req_valid` with its payload, stay stable until accepted.
- R10: After reset every entry is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = word write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read word, or the write data echoed for a write |
| rsp_hit | output | 1 | Word was resident when looked up |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data for a memory write |
| mem_rsp_valid | input | 1 | Memory read data offered |
| mem_rsp_ready | output | 1 | Block is waiting for read data |
| mem_rsp_rdata | input | 32 | Memory read data |

## Verification
The assertions take for granted that the memory side answers each accepted read with exactly one response beat, and sends no beat without an outstanding read. They also take for granted that requesters hold a request's fields steady while `req_valid` is high and `req_ready` is low. The bench's memory responder starts a reply only after it has seen a read handshake, and it drops the beat in the cycle after the block takes it. Its driver keeps each request's fields unchanged until the accepting edge. Back-pressure on the response and memory request channels comes from fixed cycle patterns, so every stall still respects these rules.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOOK  = 3'd1,
    S_MREQ  = 3'd2,
    S_MWAIT = 3'd3,
    S_RESP  = 3'd4
  } lookup_state_e;

endpackage

// File: rtl/sa4_way_match.sv
module sa4_way_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  input  logic [WAYS-1:0]               way_vld,
  input  logic [WAYS-1:0][DATA_W-1:0]   way_data,
  input  logic [TAG_W-1:0]              probe_tag,
  output logic [WAYS-1:0]               way_hit,
  output logic                          hit,
  output logic [WAY_W-1:0]              hit_way,
  output logic [DATA_W-1:0]             hit_data
);

  // one comparator per way, all working at once
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = way_vld[w] && (way_tag[w] == probe_tag);
  end

  assign hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  // word select steered by the matching way
  assign hit_data = way_data[hit_way];

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R8

endmodule

// File: rtl/sa4_lru_age.sv
module sa4_lru_age #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [WAYS-1:0]    way_vld,
  input  logic               touch_en,
  input  logic [WAY_W-1:0]   touch_way,
  output logic [WAY_W-1:0]   victim_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // per set, each way carries its rank: 0 = newest, WAYS-1 = oldest
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[set_idx][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[set_idx][w] <= '0;
        end else if (age_q[set_idx][w] < touched_age) begin
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
        end
      end
    end
  end

  // empty ways first (lowest index), otherwise the oldest way
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !way_vld[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_idx][w] == OLDEST) victim_way = WAY_W'(w);
      end
    end
  end

  logic [WAYS-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int w = 0; w < WAYS; w++) rank_seen[age_q[set_idx][w]] = 1'b1;
  end

  AST_RANKS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    &rank_seen); // R5

  AST_FILL_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !(&way_vld)) |-> !way_vld[victim_way]); // R4

endmodule

// File: rtl/sa4_cache_lookup.sv
module sa4_cache_lookup
  import sa4_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  lookup_state_e     state_q;
  logic              op_write_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic [TAG_W-1:0]  tag_mem [SETS][WAYS];
  logic [DATA_W-1:0] dat_mem [SETS][WAYS];
  logic [WAYS-1:0]   vld_q   [SETS];

  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  op_tag;
  assign set_idx = op_addr_q[OFF_W +: IDX_W];
  assign op_tag  = op_addr_q[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0][TAG_W-1:0]  row_tag;
  logic [WAYS-1:0][DATA_W-1:0] row_dat;
  logic [WAYS-1:0]             row_vld;

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_tag[w] = tag_mem[set_idx][w];
    assign row_dat[w] = dat_mem[set_idx][w];
  end
  assign row_vld = vld_q[set_idx];

  logic [WAYS-1:0]   way_hit;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [DATA_W-1:0] hit_data;
  logic [WAY_W-1:0]  victim_way;

  sa4_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .way_tag   (row_tag),
    .way_vld   (row_vld),
    .way_data  (row_dat),
    .probe_tag (op_tag),
    .way_hit   (way_hit),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_data  (hit_data)
  );

  logic             look_now;
  logic             fill_fire;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;

  assign look_now  = (state_q == S_LOOK);
  assign fill_fire = (state_q == S_MWAIT) && mem_rsp_valid;
  assign touch_en  = (look_now && hit) || fill_fire;
  assign touch_way = look_now ? hit_way : victim_way;

  sa4_lru_age #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .way_vld    (row_vld),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .victim_way (victim_way)
  );

  // control path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_write_q <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          op_write_q <= req_write;
          op_addr_q  <= req_addr;
          op_wdata_q <= req_wdata;
          state_q    <= S_LOOK;
        end
        S_LOOK: begin
          rsp_hit_q <= hit;
          if (op_write_q) begin
            rsp_data_q <= op_wdata_q;
            state_q    <= S_MREQ;
          end else if (hit) begin
            rsp_data_q <= hit_data;
            state_q    <= S_RESP;
          end else begin
            state_q    <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) state_q <= op_write_q ? S_RESP : S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          rsp_data_q <= mem_rsp_rdata;
          state_q    <= S_RESP;
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // valid bits, cleared by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_fire) begin
      vld_q[set_idx][victim_way] <= 1'b1;
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (look_now && op_write_q && hit) begin
      dat_mem[set_idx][hit_way] <= op_wdata_q;
    end
    if (fill_fire) begin
      tag_mem[set_idx][victim_way] <= op_tag;
      dat_mem[set_idx][victim_way] <= mem_rsp_rdata;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_rdata     = rsp_data_q;
  assign rsp_hit       = rsp_hit_q;
  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_write = op_write_q;
  assign mem_req_addr  = {op_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = op_wdata_q;
  assign mem_rsp_ready = (state_q == S_MWAIT);

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit))); // R9

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata))); // R9

  AST_MEM_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R3

  AST_READ_HIT_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (look_now && !op_write_q && hit) |=> (rsp_valid && rsp_hit && !mem_req_valid)); // R2

  AST_WRITE_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (look_now && op_write_q) |=> (mem_req_valid && mem_req_write)); // R6

endmodule

// File: tb/sa4_cache_lookup_bench.sv
module sa4_cache_lookup_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa4_cache_lookup u_sa4_cache_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata)
  );

  typedef struct { string req; bit hit; logic [31:0] data; } rsp_exp_t;
  typedef struct { string req; bit wr; logic [31:0] addr; logic [31:0] data; } mem_exp_t;

  rsp_exp_t    rsp_q [$];
  mem_exp_t    mem_q [$];
  logic [31:0] ref_mem [bit [29:0]];
  logic [31:0] bus_mem [bit [29:0]];
  bit   [21:0] lru_list [256][$];

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] seed_word(bit [29:0] w);
    return (32'(w) * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // driver: updates the reference model, queues expectations, then drives
  task automatic do_op(string req, bit wr, logic [31:0] addr, logic [31:0] wd);
    bit [7:0]    s = addr[9:2];
    bit [21:0]   t = addr[31:10];
    bit [29:0]   wi = addr[31:2];
    int          pos = -1;
    logic [31:0] rd;
    for (int i = 0; i < lru_list[s].size(); i++) if (lru_list[s][i] == t) pos = i;
    if (wr) begin
      if (pos >= 0) begin lru_list[s].delete(pos); lru_list[s].push_front(t); end
      ref_mem[wi] = wd;
      rsp_q.push_back('{req, pos >= 0, wd});
      mem_q.push_back('{req, 1'b1, {addr[31:2], 2'b00}, wd});
    end else begin
      rd = ref_mem.exists(wi) ? ref_mem[wi] : seed_word(wi);
      if (pos >= 0) begin
        lru_list[s].delete(pos);
        lru_list[s].push_front(t);
      end else begin
        lru_list[s].push_front(t);
        if (lru_list[s].size() > 4) void'(lru_list[s].pop_back());
        mem_q.push_back('{req, 1'b0, {addr[31:2], 2'b00}, 32'h0});
      end
      rsp_q.push_back('{req, pos >= 0, rd});
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "req_ready after accept", 32'(req_ready), 32'd0);
  endtask

  // monitor: response channel scoreboard
  initial begin
    rsp_exp_t e;
    forever begin
      @(negedge clk);
      rsp_ready = (cyc % 5) != 3;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (rsp_q.size() == 0) begin
          chk("R9", "unexpected response", 32'd1, 32'd0);
        end else begin
          e = rsp_q.pop_front();
          chk(e.req, "rsp_hit", 32'(rsp_hit), 32'(e.hit));
          chk(e.req, "rsp_rdata", rsp_rdata, e.data);
        end
      end
    end
  end

  // memory responder with its own scoreboard of memory traffic
  initial begin
    int          wait_cnt = 0;
    bit          rsp_hs = 1'b0;
    logic [31:0] pend = '0;
    mem_exp_t    m;
    forever begin
      @(negedge clk);
      if (rsp_hs) begin mem_rsp_valid = 1'b0; rsp_hs = 1'b0; end
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_rdata = pend; end
      end
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_q.size() == 0) begin
          chk("R2", "unexpected memory request", 32'd1, 32'd0);
        end else begin
          m = mem_q.pop_front();
          chk(m.req, "mem_req_write", 32'(mem_req_write), 32'(m.wr));
          chk(m.req, "mem_req_addr", mem_req_addr, m.addr);
          if (m.wr) begin
            chk(m.req, "mem_req_wdata", mem_req_wdata, m.data);
          end
        end
        if (mem_req_write) begin
          bus_mem[mem_req_addr[31:2]] = mem_req_wdata;
        end else begin
          pend = bus_mem.exists(mem_req_addr[31:2]) ? bus_mem[mem_req_addr[31:2]]
                                                    : seed_word(mem_req_addr[31:2]);
          wait_cnt = 2;
        end
      end
      rsp_hs = mem_rsp_valid && mem_rsp_ready;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  function automatic logic [31:0] mk(int tag, int set, int off);
    return {22'(tag), 8'(set), 2'(off)};
  endfunction

  initial begin
    int unsigned seed = 32'h2468_ACE1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle state after reset
    chk("R10", "req_ready", 32'(req_ready), 32'd1);
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10", "mem_req_valid", 32'(mem_req_valid), 32'd0);

    // R3 miss then R2 hit, R1 byte offset ignored
    do_op("R3", 0, mk(7, 1, 0), 0);
    do_op("R2", 0, mk(7, 1, 0), 0);
    do_op("R1", 0, mk(7, 1, 3), 0);
    // R1: same tag, different set is a separate entry
    do_op("R1", 0, mk(7, 2, 1), 0);
    do_op("R1", 0, mk(7, 2, 0), 0);

    // R4: fill four ways of set 5, all stay resident
    for (int t = 0; t < 4; t++) do_op("R4", 0, mk(16 + t, 5, 0), 0);
    for (int t = 0; t < 4; t++) do_op("R4", 0, mk(16 + t, 5, 2), 0);

    // R5: touch oldest, then fill evicts the least recently used
    do_op("R5", 0, mk(16, 5, 0), 0);
    do_op("R5", 0, mk(40, 5, 0), 0);
    do_op("R5", 0, mk(16, 5, 0), 0);
    do_op("R5", 0, mk(17, 5, 0), 0);
    do_op("R5", 0, mk(18, 5, 0), 0);

    // R6: write hit updates and goes out; read back hits with new data
    do_op("R6", 1, mk(16, 5, 2), 32'hCAFE_0001);
    do_op("R6", 0, mk(16, 5, 0), 0);

    // R7: write miss does not allocate or reorder
    do_op("R7", 1, mk(90, 5, 0), 32'hBEEF_0090);
    do_op("R7", 0, mk(90, 5, 0), 0);
    do_op("R7", 0, mk(90, 5, 0), 0);

    // mixed traffic over a few sets and tags
    for (int i = 0; i < 300; i++) begin
      int tg, st, of;
      bit wr;
      seed = seed * 32'd1103515245 + 32'd12345;
      tg = int'((seed >> 8) % 6);
      st = ((seed >> 16) % 3 == 0) ? 3 : (((seed >> 16) % 3 == 1) ? 4 : 200);
      of = int'((seed >> 20) % 4);
      wr = ((seed >> 24) % 4) == 0;
      do_op(wr ? "R6" : "R5", wr, mk(tg, st, of), seed ^ 32'h5A5A_0000);
    end

    while (rsp_q.size() != 0 || mem_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule